// File: doc/BRIEF.md
# I2C EEPROM Slave Read Engine

This block is the read side of a 16K-byte serial EEPROM that sits on a two-wire I2C bus as a slave. The clock and data lines reach it as ordinary inputs. They are resynchronised to the system clock and their edges are found there. The block drives the data line only through an open-drain pull-down enable. Byte contents come from an on-chip content generator that is indexed by a 14-bit address counter.

A master sets the counter with a dummy write. It sends the device byte with the direction bit clear, then the high address byte, then the low address byte. It then issues a repeated START and the device byte with the direction bit set, and reads from the chosen location. A read that begins with no address write returns data from wherever the counter points. Each returned byte moves the counter up by one. The master asks for further bytes by acknowledging each one. It ends the read by leaving one byte unacknowledged and then sending STOP. After the last location the counter wraps to zero.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: After reset the data-line pull-down (`sda_oe_o`, 1 = pull SDA low) is off and the address counter is 0, so a first read with no address write returns the byte at address 0.
- R2: The device byte is received MSB first: bits 7..4 are the type code 1010, bits 3..1 must equal `cs_i`, and bit 0 is the direction (1 = read). When it matches, the slave pulls SDA low during the following (9th) clock as acknowledge.
- R3: A device byte with a wrong type code or wrong chip-select bits gets no acknowledge, and SDA stays released for the rest of that transfer.
- R4: In a write-direction transfer the next two bytes are the address, high byte first. Each is acknowledged. The counter is loaded with {high[5:0], low}, so the top two bits of the high byte are ignored.
- R5: After a read-direction device byte, the slave shifts out the byte at the counter, MSB first, starting on the SCL low phase that follows its acknowledge.
- R6: A read with no preceding address write returns the byte at the current counter value.
- R7: A master ACK (SDA low in the 9th clock) after a data byte makes the slave send the byte at the next address. A master NACK makes it release SDA and ignore the bus until the next START or STOP.
- R8: Every byte sent advances the counter by one over all 14 bits, and address 16383 is followed by address 0 without a break.
- R9: The byte stored at address A is A[7:0] XOR {A[13:8], 2'b10}.
- R10: The slave begins pulling SDA low only while SCL is low.
- R11: A START or STOP seen at any point aborts the transfer and keeps the counter. A dummy write cut off before the low address byte is acknowledged leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| cs_i | input | 3 | Chip-select straps compared with device byte bits 3..1 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench reads across the top of the array: it sets the address to 16382 and reads four bytes. A counter that saturated or dropped its carry would return the wrong bytes after 16383. The high address byte is sent with random top bits, so a design that kept those bits would read from the wrong location. It sends device bytes with a wrong strap and with a wrong type code, then checks that no acknowledge comes and that SDA stays high. It also cuts off dummy writes with a STOP and with a repeated START before the low byte, then checks that the counter has not moved. A design that loaded the counter early, or one that stalled after an abort, would fail these checks.

// File: rtl/i2c_eeprom_rd_pkg.sv
package i2c_eeprom_rd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RACK,
        S_TX,
        S_MACK,
        S_WAIT
    } rd_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO
    } rd_phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_rom_pattern.sv
module i2c_rom_pattern #(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        data_o
);

    always_comb begin
        data_o = addr_i[7:0] ^ 8'({addr_i[ADDR_W-1:8], 2'b10});
    end

endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
    import i2c_eeprom_rd_pkg::*;
#(
    parameter int         ADDR_W      = 14,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] cs_i,
    output logic       sda_oe_o
);

    localparam int BIT_W = 4;

    typedef struct packed {
        rd_state_e         state;
        rd_phase_e         phase;
        logic [BIT_W-1:0]  bitcnt;
        logic [7:0]        sh;
        logic [7:0]        hi;
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic              rw;
        logic              mack;
        logic              scl_p;
        logic              sda_p;
    } core_t;

    core_t q, d;

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic [7:0] rom_data;
    logic       scl_rise, scl_fall, start_c, stop_c, load_c;

    i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_rom_pattern #(.ADDR_W(ADDR_W)) u_rom (
        .addr_i (q.addr),
        .data_o (rom_data)
    );

    always_comb begin
        scl_rise = scl_s & ~q.scl_p;
        scl_fall = ~scl_s & q.scl_p;
        start_c  = q.sda_p & ~sda_s & scl_s & q.scl_p;
        stop_c   = ~q.sda_p & sda_s & scl_s & q.scl_p;
        load_c   = 1'b0;

        d       = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;

        if (stop_c) begin
            d.state = S_IDLE;
            d.oe    = 1'b0;
        end else if (start_c) begin
            d.state  = S_RX;
            d.phase  = PH_DEV;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else begin
            case (q.state)
                S_RX: begin
                    if (scl_rise && q.bitcnt < BIT_W'(8)) begin
                        d.sh     = {q.sh[6:0], sda_s};
                        d.bitcnt = q.bitcnt + BIT_W'(1);
                    end else if (scl_fall && q.bitcnt == BIT_W'(8)) begin
                        case (q.phase)
                            PH_DEV: begin
                                if (q.sh[7:1] == {DEV_CODE, cs_i}) begin
                                    d.rw    = q.sh[0];
                                    d.oe    = 1'b1;
                                    d.state = S_RACK;
                                end else begin
                                    d.state = S_WAIT;
                                end
                            end
                            PH_AHI: begin
                                d.hi    = q.sh;
                                d.oe    = 1'b1;
                                d.state = S_RACK;
                            end
                            default: begin
                                d.oe    = 1'b1;
                                d.state = S_RACK;
                            end
                        endcase
                    end
                end
                S_RACK: begin
                    if (scl_fall) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        case (q.phase)
                            PH_DEV: begin
                                if (q.rw) begin
                                    load_c = 1'b1;
                                end else begin
                                    d.phase = PH_AHI;
                                    d.state = S_RX;
                                end
                            end
                            PH_AHI: begin
                                d.phase = PH_ALO;
                                d.state = S_RX;
                            end
                            default: begin
                                d.addr  = ADDR_W'({q.hi, q.sh});
                                d.state = S_WAIT;
                            end
                        endcase
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.bitcnt == BIT_W'(8)) begin
                            d.oe    = 1'b0;
                            d.mack  = 1'b0;
                            d.state = S_MACK;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.oe     = ~q.sh[6];
                            d.bitcnt = q.bitcnt + BIT_W'(1);
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            load_c = 1'b1;
                        end else begin
                            d.oe    = 1'b0;
                            d.state = S_WAIT;
                        end
                    end
                end
                default: ;
            endcase

            if (load_c) begin
                d.sh     = rom_data;
                d.oe     = ~rom_data[7];
                d.bitcnt = BIT_W'(1);
                d.addr   = q.addr + ADDR_W'(1);
                d.state  = S_TX;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.phase <= PH_DEV;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    // R10: a pull-down only starts after the synchronised clock was low
    a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !$past(scl_s));

    // R3: after a mismatch or a NACK the line stays released
    a_r3_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_WAIT || q.state == S_IDLE) |-> !q.oe);

    // R2: the device acknowledge is given only for a matching device byte
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_RACK && q.phase == PH_DEV) |-> (q.sh[7:1] == {DEV_CODE, cs_i}));

    // R8: the counter wraps from the top address to zero when a byte is fetched
    a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_c) && $past(q.addr) == {ADDR_W{1'b1}}) |-> (q.addr == '0));

    // R11: a START always restarts reception of a device byte, line released
    a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_c) |-> (q.state == S_RX && q.phase == PH_DEV && !q.oe));

    // R5: the bit counter never runs past one byte
    a_r5_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.bitcnt <= BIT_W'(8));

endmodule

// File: tb/i2c_eeprom_rd_test.sv
module i2c_eeprom_rd_test;

    localparam int         CLK_PERIOD = 10;
    localparam int         QTR        = 4;
    localparam logic [2:0] CS         = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int n_checks = 0;
    int n_errors = 0;
    int viol = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;
    logic [13:0] exp_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_rd uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .cs_i     (CS),
        .sda_oe_o (sda_oe)
    );

    // R10 monitor: pull-down must start while the bus clock is low
    always @(posedge clk) begin
        if (sda_oe && !oe_prev && scl_m) viol++;
        oe_prev <= sda_oe;
    end

    function automatic logic [7:0] pat(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b10};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack_n);
    endtask

    task automatic recv_byte(input logic more, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~more);
    endtask

    task automatic read_run(input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            chk("R5 R7 R9 data byte", {24'd0, v}, {24'd0, pat(exp_addr)});
            exp_addr = exp_addr + 14'd1;
        end
        i2c_stop();
        chk("R7 released after NACK", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic set_addr(input logic [15:0] a16);
        logic ack_n;
        i2c_start();
        send_byte({4'b1010, CS, 1'b0}, ack_n);
        chk("R2 write device ack", {31'd0, ack_n}, 32'd0);
        send_byte(a16[15:8], ack_n);
        chk("R4 high address ack", {31'd0, ack_n}, 32'd0);
        send_byte(a16[7:0], ack_n);
        chk("R4 low address ack", {31'd0, ack_n}, 32'd0);
        exp_addr = a16[13:0];
    endtask

    task automatic sel_read(input logic [15:0] a16, input int n);
        logic ack_n;
        set_addr(a16);
        i2c_start();
        send_byte({4'b1010, CS, 1'b1}, ack_n);
        chk("R2 read device ack", {31'd0, ack_n}, 32'd0);
        read_run(n);
    endtask

    task automatic cur_read(input int n, input string tag);
        logic ack_n;
        i2c_start();
        send_byte({4'b1010, CS, 1'b1}, ack_n);
        chk("R2 R6 read device ack", {31'd0, ack_n}, 32'd0);
        if (n > 0) begin
            logic [7:0] v;
            for (int i = 0; i < n; i++) begin
                recv_byte(i < n - 1, v);
                chk(tag, {24'd0, v}, {24'd0, pat(exp_addr)});
                exp_addr = exp_addr + 14'd1;
            end
        end
        i2c_stop();
    endtask

    task automatic bad_device(input logic [7:0] dev, input string tag);
        logic ack_n;
        logic b;
        int highs;
        highs = 0;
        i2c_start();
        send_byte(dev, ack_n);
        chk(tag, {31'd0, ack_n}, 32'd1);
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            if (b) highs++;
        end
        chk("R3 line stays released", highs, 9);
        i2c_stop();
    endtask

    initial begin
        logic ack_n;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        chk("R1 reset pull-down off", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle after reset", {31'd0, sda_oe}, 32'd0);

        cur_read(2, "R1 R6 first read from zero");

        // R8 wrap across the top of the array
        sel_read(16'h3FFE, 4);

        // R4 ignored top bits of high byte
        sel_read(16'hC123, 2);

        // R3 wrong strap and wrong type code
        bad_device({4'b1010, CS ^ 3'b001, 1'b1}, "R3 no ack on strap mismatch");
        bad_device({4'b1011, CS, 1'b1}, "R3 no ack on type mismatch");
        cur_read(1, "R3 R6 counter kept after mismatch");

        // R11 dummy write cut by STOP after high byte
        i2c_start();
        send_byte({4'b1010, CS, 1'b0}, ack_n);
        send_byte(8'h2A, ack_n);
        i2c_stop();
        cur_read(1, "R11 counter kept after STOP abort");

        // R11 dummy write cut by repeated START inside the high byte
        i2c_start();
        send_byte({4'b1010, CS, 1'b0}, ack_n);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        cur_read(1, "R11 counter kept after START abort");

        // random selective and sequential reads
        for (int k = 0; k < 12; k++) begin
            logic [15:0] a16;
            int n;
            a16 = 16'($urandom);
            n = 1 + int'($urandom % 5);
            sel_read(a16, n);
            cur_read(1 + int'($urandom % 3), "R6 R8 current read continues");
        end

        chk("R10 pull starts only with SCL low", viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule